// File: doc/BRIEF.md
# Serial Memory Read Target

This block is the target side of a two-wire serial bus that serves read requests from a byte-addressed memory held inside the block. It watches a synchronised copy of the clock and data lines. It recognises START, repeated START and STOP conditions and checks the seven-bit device code carried by the first byte of each transfer. It answers by pulling the data line low through an open-drain output enable. It never drives the line high.

A persistent address counter selects the byte to send. A controller can read from wherever the counter points, either one byte or a stream. It can also first load a new counter value with a write header that carries two address bytes and no data, then turn the transfer into a read with a repeated START. After every byte it returns, the block samples the controller's acknowledge. An acknowledge asks for the next byte; a missing acknowledge ends the stream.

The state machine has twelve states:
- `ST_IDLE`: the bus is free.
- `ST_DEV`: the device select byte is being shifted in.
- `ST_ACK_WR`, `ST_ACK_RD`: the device select byte is acknowledged for a write header or for a read.
- `ST_AHI`, `ST_ACK_HI`: the upper address byte is received, then acknowledged.
- `ST_ALO`, `ST_ACK_LO`: the lower address byte is received, then acknowledged.
- `ST_WAIT_RS`: the address is loaded and the block waits for a repeated START.
- `ST_TX`: a data byte is being shifted out.
- `ST_TX_ACK`: the controller's acknowledge is sampled.
- `ST_DROP`: the bus is ignored until the next condition.

The transitions are:
- A STOP moves any state to `ST_IDLE`. A START moves any state to `ST_DEV`.
- From `ST_DEV`, a matching code goes to `ST_ACK_RD` or `ST_ACK_WR`, chosen by the R/W bit. A code that does not match goes to `ST_DROP`.
- `ST_ACK_WR` leads to `ST_AHI`, then `ST_ACK_HI`, `ST_ALO`, `ST_ACK_LO` and `ST_WAIT_RS`.
- `ST_ACK_RD` leads to `ST_TX`, then `ST_TX_ACK`. From `ST_TX_ACK`, an acknowledge goes back to `ST_TX` and a missing acknowledge goes to `ST_DROP`.

Top module: `smr_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and the address counter holds 0, so the first current-address read returns the byte at address 0.
- R2: A device select byte whose upper seven bits equal `DEV_CODE` (default 7'b1010000) is acknowledged by driving `sda_oe` high during the ninth clock. Bit 0 is R/W, where 1 means read.
- R3: A device select byte with any other upper seven bits gets no acknowledge. `sda_oe` stays 0 until the next START or STOP, and the address counter does not change.
- R4: A write header (R/W = 0) is followed by an upper and then a lower address byte, each acknowledged. After the lower byte, the counter takes the low `ADDR_W` bits of {upper, lower}.
- R5: A repeated START after the address load, followed by a matching read header, returns the byte at the loaded address.
- R6: A read header that follows a START with no address load returns the byte at the current counter value.
- R7: The counter advances by one after every byte handed out and wraps from `MAX_ADDR` (default 16383) to 0.
- R8: While the controller acknowledges, the block sends the following byte. After a missing acknowledge, `sda_oe` stays 0 and no further byte is sent.
- R9: The byte stored at address A is A[7:0] XOR A[15:8], with A zero-extended to 16 bits. Bytes are sent most significant bit first.
- R10: The level of `wc_i` has no effect on any read.
- R11: `sda_oe` changes only while SCL is low.
- R12: A START in any state restarts device select reception, and a STOP returns to idle. An address header cut short by either leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| wc_i | input | 1 | Write-control level, no effect on reads |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The bench reads with each of the four header patterns:
- A current-address single read shows that the counter persists between transfers.
- A random single read shows that the address is loaded in the right byte order.
- A random stream started two bytes below the top address exposes any fault in the wrap.
- A current stream separates the acknowledge from the missing acknowledge.

Beyond the four patterns:
- A wrong device code, followed by a read that must come from the unchanged counter, tells a silent drop from a partial response.
- Header bytes wider than the counter show which bits are dropped.
- A header cut short by a repeated START or by a STOP shows that a partial address is never loaded.
- All of this is repeated with `wc_i` high.

// File: rtl/smr_pkg.sv
package smr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_WR,
        ST_AHI,
        ST_ACK_HI,
        ST_ALO,
        ST_ACK_LO,
        ST_WAIT_RS,
        ST_ACK_RD,
        ST_TX,
        ST_TX_ACK,
        ST_DROP
    } smr_state_e;

    localparam int BYTE_BITS = 8;
endpackage

// File: rtl/smr_sync.sv
module smr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    // Bus lines idle high, so every stage resets to ones.
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '1;
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/smr_busev.sv
module smr_busev (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // A data line edge while the clock stays high marks a bus condition.
    assign start_o = scl_q & scl_s & sda_q & ~sda_s;
    assign stop_o  = scl_q & scl_s & ~sda_q & sda_s;
    assign rise_o  = ~scl_q & scl_s;
    assign fall_o  = scl_q & ~scl_s;
endmodule

// File: rtl/smr_rom.sv
module smr_rom #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        data_o
);
    logic [15:0] wide;

    // The array contents are computed from the address, so no table is stored.
    assign wide = 16'(addr_i);

    always_ff @(posedge clk) begin
        data_o <= wide[7:0] ^ wide[15:8];
    end
endmodule

// File: rtl/smr_target.sv
module smr_target #(
    parameter logic [6:0] DEV_CODE    = 7'b1010000,
    parameter int         MAX_ADDR    = 16383,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wc_i,
    output logic sda_oe
);
    import smr_pkg::*;

    localparam int                ADDR_W = $clog2(MAX_ADDR + 1);
    localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(MAX_ADDR);
    localparam logic [3:0]        LAST_B = 4'(BYTE_BITS);

    logic scl_s, sda_s;
    logic ev_start, ev_stop, ev_rise, ev_fall;
    logic [7:0] rd_data;

    smr_state_e        state_q, state_d;
    logic [3:0]        cnt_q, cnt_d;
    logic [7:0]        sh_q, sh_d;
    logic [7:0]        ahi_q, ahi_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              oe_q, oe_d;
    logic              mack_q, mack_d;
    logic              wc_unused;

    assign wc_unused = wc_i;

    smr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    smr_busev u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    smr_rom #(.ADDR_W(ADDR_W)) u_rom (
        .clk    (clk),
        .addr_i (addr_q),
        .data_o (rd_data)
    );

    // Next-state and datapath decisions; output enable updates only on SCL falls.
    always_comb begin
        logic load_byte;
        logic [15:0] full_a;
        state_d   = state_q;
        cnt_d     = cnt_q;
        sh_d      = sh_q;
        ahi_d     = ahi_q;
        addr_d    = addr_q;
        oe_d      = oe_q;
        mack_d    = mack_q;
        load_byte = 1'b0;
        full_a    = {ahi_q, sh_q};
        if (ev_stop) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else if (ev_start) begin
            state_d = ST_DEV;
            cnt_d   = '0;
            oe_d    = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_WAIT_RS, ST_DROP: begin
                end
                ST_DEV: begin
                    if (ev_rise) begin
                        sh_d  = {sh_q[6:0], sda_s};
                        cnt_d = cnt_q + 4'd1;
                    end else if (ev_fall && cnt_q == LAST_B) begin
                        if (sh_q[7:1] == DEV_CODE) begin
                            oe_d    = 1'b1;
                            state_d = sh_q[0] ? ST_ACK_RD : ST_ACK_WR;
                        end else begin
                            state_d = ST_DROP;
                        end
                    end
                end
                ST_ACK_WR: begin
                    if (ev_fall) begin
                        oe_d    = 1'b0;
                        cnt_d   = '0;
                        state_d = ST_AHI;
                    end
                end
                ST_AHI: begin
                    if (ev_rise) begin
                        sh_d  = {sh_q[6:0], sda_s};
                        cnt_d = cnt_q + 4'd1;
                    end else if (ev_fall && cnt_q == LAST_B) begin
                        ahi_d   = sh_q;
                        oe_d    = 1'b1;
                        state_d = ST_ACK_HI;
                    end
                end
                ST_ACK_HI: begin
                    if (ev_fall) begin
                        oe_d    = 1'b0;
                        cnt_d   = '0;
                        state_d = ST_ALO;
                    end
                end
                ST_ALO: begin
                    if (ev_rise) begin
                        sh_d  = {sh_q[6:0], sda_s};
                        cnt_d = cnt_q + 4'd1;
                    end else if (ev_fall && cnt_q == LAST_B) begin
                        addr_d  = ADDR_W'(full_a);
                        oe_d    = 1'b1;
                        state_d = ST_ACK_LO;
                    end
                end
                ST_ACK_LO: begin
                    if (ev_fall) begin
                        oe_d    = 1'b0;
                        state_d = ST_WAIT_RS;
                    end
                end
                ST_ACK_RD: begin
                    if (ev_fall) begin
                        load_byte = 1'b1;
                    end
                end
                ST_TX: begin
                    if (ev_fall) begin
                        if (cnt_q == 4'd7) begin
                            oe_d    = 1'b0;
                            state_d = ST_TX_ACK;
                        end else begin
                            sh_d  = {sh_q[6:0], 1'b0};
                            oe_d  = ~sh_q[6];
                            cnt_d = cnt_q + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev_rise) begin
                        mack_d = ~sda_s;
                    end else if (ev_fall) begin
                        if (mack_q) begin
                            load_byte = 1'b1;
                        end else begin
                            state_d = ST_DROP;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
            if (load_byte) begin
                sh_d    = rd_data;
                oe_d    = ~rd_data[7];
                cnt_d   = '0;
                addr_d  = (addr_q == TOP_A) ? '0 : addr_q + 1'b1;
                state_d = ST_TX;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            ahi_q  <= '0;
            addr_q <= '0;
            oe_q   <= 1'b0;
            mack_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            ahi_q  <= ahi_d;
            addr_q <= addr_d;
            oe_q   <= oe_d;
            mack_q <= mack_d;
        end
    end

    assign sda_oe = oe_q;

    // R11: the output enable only moves after a cycle in which SCL was low.
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R2: the data line is left free while header bits are shifted in.
    assert_no_drive_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV || state_q == ST_AHI || state_q == ST_ALO) |-> !sda_oe);

    // R3: once dropped, the block stays off the bus.
    assert_drop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |-> !sda_oe);

    // R8: the controller's acknowledge slot is never driven.
    assert_ack_slot_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX_ACK) |-> !sda_oe);

    // R7: a counter change that is not an address load is a single wrapping step.
    assert_counter_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_q != $past(addr_q)) && ($past(state_q) != ST_ALO)) |->
        (addr_q == (($past(addr_q) == TOP_A) ? '0 : $past(addr_q) + 1'b1)));

    // R12: a START always leads into device select reception.
    assert_start_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (state_q == ST_DEV));
endmodule

// File: tb/smr_target_bench.sv
`timescale 1ns/1ps
module smr_target_bench;
    localparam int Q     = 10;
    localparam int MAXA  = 16383;
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic wc = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    int maddr = 0;
    logic exp_oe = 1'b0;
    logic mon_en = 1'b0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;
    string mon_tag = "R2";
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);

    smr_target u_smr_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .wc_i   (wc),
        .sda_oe (sda_oe)
    );

    function automatic logic [7:0] mem_byte(int a);
        logic [15:0] w;
        w = 16'(a);
        return w[7:0] ^ w[15:8];
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Per-clock comparison against the bench's expected drive, taken away from the edge.
    always @(posedge clk) begin
        #1;
        if (mon_en && !done) begin
            if (scl && prev_scl) begin
                check(sda_oe == exp_oe, mon_tag, sda_oe, exp_oe);
                check(sda_oe == prev_oe, "R11", sda_oe, prev_oe);
            end
            prev_scl = scl;
            prev_oe  = sda_oe;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        exp_oe = 1'b0;
        m_low  = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_low = 1'b1;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        exp_oe = 1'b0;
        m_low  = 1'b1;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_low = 1'b0;
        tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, input logic want_ack, input string tag);
        logic got;
        for (int i = 7; i >= 0; i--) begin
            exp_oe  = 1'b0;
            mon_tag = tag;
            m_low   = ~b[i];
            tick(2 * Q);
            scl = 1'b1;
            tick(2 * Q);
            scl = 1'b0;
        end
        m_low  = 1'b0;
        exp_oe = want_ack;
        tick(2 * Q);
        scl = 1'b1;
        tick(Q);
        got = ~sda_line;
        check(got == want_ack, tag, got, want_ack);
        tick(Q);
        scl = 1'b0;
    endtask

    task automatic get_byte(input logic [7:0] expv, input logic active, input logic give_ack, input string tag);
        logic [7:0] v;
        logic [7:0] want;
        want = active ? expv : 8'hFF;
        mon_tag = tag;
        for (int i = 7; i >= 0; i--) begin
            m_low  = 1'b0;
            exp_oe = ~want[i];
            tick(2 * Q);
            scl = 1'b1;
            tick(Q);
            v[i] = sda_line;
            tick(Q);
            scl = 1'b0;
        end
        check(v == want, tag, v, want);
        m_low  = give_ack;
        exp_oe = 1'b0;
        tick(2 * Q);
        scl = 1'b1;
        tick(2 * Q);
        scl = 1'b0;
    endtask

    task automatic read_run(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            get_byte(mem_byte(maddr), 1'b1, k < n - 1, tag);
            maddr = (maddr == MAXA) ? 0 : maddr + 1;
        end
    endtask

    task automatic set_addr(input int a, input string tag);
        bus_start();
        put_byte(8'hA0, 1'b1, tag);
        put_byte(8'((a >> 8) & 255), 1'b1, tag);
        put_byte(8'(a & 255), 1'b1, tag);
        maddr = a & MAXA;
    endtask

    task automatic cur_read(input int n, input string tag);
        bus_start();
        put_byte(8'hA1, 1'b1, tag);
        read_run(n, tag);
        bus_stop();
    endtask

    initial begin
        tick(5);
        check(sda_oe == 1'b0, "R1", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);
        mon_en = 1'b1;
        check(sda_oe == 1'b0, "R1", sda_oe, 0);
        // R1/R6: counter starts at zero.
        cur_read(1, "R1");
        // R5: random single read.
        set_addr(16'h0123, "R4");
        cur_read(1, "R5");
        // R6: current read follows on.
        cur_read(1, "R6");
        // R7: stream across the top address.
        set_addr(16'h3FFE, "R4");
        cur_read(4, "R7");
        // R8: current stream with acknowledges, ended by no acknowledge.
        cur_read(3, "R8");
        // R9: contents at a mixed address.
        set_addr(16'h1234, "R4");
        cur_read(2, "R9");
        // R3: foreign device code is ignored, counter kept.
        bus_start();
        put_byte(8'hB1, 1'b0, "R3");
        get_byte(8'h00, 1'b0, 1'b0, "R3");
        bus_stop();
        bus_start();
        put_byte(8'hA2, 1'b0, "R2");
        bus_stop();
        cur_read(1, "R3");
        // R10: write-control high changes nothing.
        wc = 1'b1;
        set_addr(16'h2A55, "R10");
        cur_read(2, "R10");
        wc = 1'b0;
        // R4: bits above the counter width are dropped.
        set_addr(16'hFF01, "R4");
        cur_read(1, "R4");
        // R12: header cut by repeated START, then by STOP.
        bus_start();
        put_byte(8'hA0, 1'b1, "R12");
        put_byte(8'h05, 1'b1, "R12");
        cur_read(1, "R12");
        bus_start();
        put_byte(8'hA0, 1'b1, "R12");
        bus_stop();
        cur_read(1, "R12");
        tick(10);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule